// File: doc/BRIEF.md
# Data Alignment Check and Fault Unit

This unit sits in the load/store path of a processor. For each data access it takes the byte address and the access size (byte, halfword or word). It then chooses one of four outcomes: the access is aligned and passes unchanged, it is misaligned and aborts, it is misaligned and goes through as a true unaligned access, or it is misaligned and becomes an aligned word access whose returned data is rotated. The unit holds two control bits that select the outcome. One enables strict alignment checking. The other enables support for unaligned accesses. Strict checking always wins over unaligned support.

Every accepted access produces one registered result one cycle later. The result holds a valid flag, a fault flag, a memory-request flag, a two-bit mode code, the address to present to memory and a right-rotate amount for the load data. The unit accepts a new access every cycle. Splitting an access into two bus transfers, byte swapping for endianness and the memory itself are handled outside this unit.

Top module: `aln_check_unit`

## Requirements
- R1: A synchronous reset (rstN low at a clock edge) clears outValid, outFault and outMemReq and clears the strict bit. It loads the unaligned-support bit from the strapUnal input.
- R2: Size codes are 2'b00 byte, 2'b01 halfword, 2'b10 or 2'b11 word. A byte is never misaligned. A halfword is misaligned when address bit 0 is 1. A word is misaligned when address bits [1:0] are nonzero.
- R3: With the strict bit set, a misaligned access gives outFault=1, outMemReq=0, outMode=2'd3, outAddr=0 and outRotate=0, whatever the unaligned-support bit holds.
- R4: With strict clear and unaligned support set, a misaligned access gives outFault=0, outMemReq=1, outMode=2'd1, outAddr equal to the request address and outRotate=0.
- R5: With both bits clear, a misaligned load gives outMemReq=1, outMode=2'd2, outAddr equal to the address with bits [1:0] cleared, and outRotate=8*addr[1:0].
- R6: With both bits clear, a misaligned store gives outMode=2'd2, outAddr with bits [1:0] cleared and outRotate=0.
- R7: An aligned access, under any control setting, gives outFault=0, outMemReq=1, outMode=2'd0, outAddr equal to the request address and outRotate=0.
- R8: outValid in a cycle equals reqValid in the cycle before. Back-to-back accesses each produce a result, one per cycle and in order. While outValid is 0, outFault and outMemReq are 0.
- R9: A control write (ctrlWe=1) takes effect at the next clock edge. An access presented in the same cycle as the write is judged with the old bits.
- R10: outFault and outMemReq are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapUnal | input | 1 | Reset value of the unaligned-support bit |
| ctrlWe | input | 1 | Load both control bits |
| ctrlStrict | input | 1 | New strict-alignment bit |
| ctrlUnal | input | 1 | New unaligned-support bit |
| reqValid | input | 1 | Access present this cycle |
| reqWrite | input | 1 | 1 for store, 0 for load |
| reqSize | input | 2 | Access size code |
| reqAddr | input | ADDR_W | Byte address |
| outValid | output | 1 | Result valid |
| outFault | output | 1 | Alignment abort |
| outMemReq | output | 1 | Memory request for this access |
| outMode | output | 2 | 0 aligned, 1 unaligned pass, 2 rotated, 3 fault |
| outAddr | output | ADDR_W | Address presented to memory |
| outRotate | output | ROT_W | Right-rotate amount in bits for load data |

## Verification
The hardest case to reach from the ports is a control write and a misaligned access in the same cycle, followed at once by a second misaligned access. This is the only way to show that the first access still sees the old bits and the second sees the new ones. The bench drives exactly this pair back to back. Its model updates its own control copy only after it has computed the expectation for the access in the write cycle. The reset value of the unaligned bit is tested by resetting twice with different strap levels, each time followed by a misaligned word load.

// File: rtl/aln_pkg.sv
package aln_pkg;

  typedef enum logic [1:0] {
    MODE_ALIGNED = 2'd0,
    MODE_PASS    = 2'd1,
    MODE_ROTATE  = 2'd2,
    MODE_FAULT   = 2'd3
  } alnMode_e;

  localparam logic [1:0] SIZE_BYTE = 2'b00;
  localparam logic [1:0] SIZE_HALF = 2'b01;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch an address for a non-faulting access
    logic clearLow;  // drop the lane bits of the address
    logic rotate;    // produce a load rotate amount
  } alnStrobe_t;

endpackage

// File: rtl/aln_ctrl.sv
module aln_ctrl
  import aln_pkg::*;
#(
  parameter int LANE_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 strapUnal,
  input  logic                 ctrlWe,
  input  logic                 ctrlStrict,
  input  logic                 ctrlUnal,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [1:0]           reqSize,
  input  logic [LANE_BITS-1:0] reqLane,
  output alnStrobe_t           strobe,
  output logic                 outValid,
  output logic                 outFault,
  output logic                 outMemReq,
  output logic [1:0]           outMode
);

  logic strictQ;
  logic unalQ;
  logic misal;
  logic isFault;
  logic isPass;
  logic isLegacy;
  alnMode_e modeNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strictQ <= 1'b0;
      unalQ   <= strapUnal;
    end else if (ctrlWe) begin
      strictQ <= ctrlStrict;
      unalQ   <= ctrlUnal;
    end
  end

  always_comb begin
    case (reqSize)
      SIZE_BYTE: misal = 1'b0;
      SIZE_HALF: misal = reqLane[0];
      default:   misal = |reqLane;
    endcase
  end

  assign isFault  = reqValid & misal & strictQ;
  assign isPass   = reqValid & misal & ~strictQ & unalQ;
  assign isLegacy = reqValid & misal & ~strictQ & ~unalQ;

  always_comb begin
    if (isFault)       modeNext = MODE_FAULT;
    else if (isPass)   modeNext = MODE_PASS;
    else if (isLegacy) modeNext = MODE_ROTATE;
    else               modeNext = MODE_ALIGNED;
  end

  assign strobe.capture  = reqValid & ~isFault;
  assign strobe.clearLow = isLegacy;
  assign strobe.rotate   = isLegacy & ~reqWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outFault  <= 1'b0;
      outMemReq <= 1'b0;
      outMode   <= MODE_ALIGNED;
    end else begin
      outValid  <= reqValid;
      outFault  <= isFault;
      outMemReq <= reqValid & ~isFault;
      outMode   <= reqValid ? modeNext : MODE_ALIGNED;
    end
  end

endmodule

// File: rtl/aln_datapath.sv
module aln_datapath
  import aln_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LANE_BITS = 2,
  parameter int ROT_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  alnStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] outAddr,
  output logic [ROT_W-1:0]  outRotate
);

  localparam int PAD_W = ROT_W - LANE_BITS;

  logic [ADDR_W-1:0] addrNext;
  logic [ROT_W-1:0]  rotNext;

  always_comb begin
    addrNext = reqAddr;
    if (strobe.clearLow) addrNext[LANE_BITS-1:0] = '0;
    rotNext = strobe.rotate ? {reqAddr[LANE_BITS-1:0], {PAD_W{1'b0}}} : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outAddr   <= '0;
      outRotate <= '0;
    end else if (strobe.capture) begin
      outAddr   <= addrNext;
      outRotate <= rotNext;
    end else begin
      outAddr   <= '0;
      outRotate <= '0;
    end
  end

endmodule

// File: rtl/aln_check_unit.sv
module aln_check_unit
  import aln_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LANE_BITS = $clog2(DATA_W / 8),
  parameter int ROT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapUnal,
  input  logic              ctrlWe,
  input  logic              ctrlStrict,
  input  logic              ctrlUnal,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              outValid,
  output logic              outFault,
  output logic              outMemReq,
  output logic [1:0]        outMode,
  output logic [ADDR_W-1:0] outAddr,
  output logic [ROT_W-1:0]  outRotate
);

  alnStrobe_t strobe;

  aln_ctrl #(.LANE_BITS(LANE_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .strapUnal(strapUnal),
    .ctrlWe(ctrlWe), .ctrlStrict(ctrlStrict), .ctrlUnal(ctrlUnal),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqLane(reqAddr[LANE_BITS-1:0]), .strobe(strobe),
    .outValid(outValid), .outFault(outFault),
    .outMemReq(outMemReq), .outMode(outMode)
  );

  aln_datapath #(.ADDR_W(ADDR_W), .LANE_BITS(LANE_BITS), .ROT_W(ROT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .outAddr(outAddr), .outRotate(outRotate)
  );

endmodule

// File: rtl/aln_check_sva.sv
module aln_check_sva #(
  parameter int ADDR_W = 32,
  parameter int ROT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              outValid,
  input logic              outFault,
  input logic              outMemReq,
  input logic [1:0]        outMode,
  input logic [ADDR_W-1:0] outAddr,
  input logic [ROT_W-1:0]  outRotate
);

  // R10
  exclusive_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(outFault && outMemReq));

  // R8
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);

  // R8
  idle_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outFault && !outMemReq));

  // R3
  fault_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    outFault |-> (outMode == 2'd3 && outAddr == '0 && outRotate == '0));

  // R5
  rotate_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outMode == 2'd2) |-> (outAddr[1:0] == 2'b00));

  // R7
  aligned_norot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outMode == 2'd0) |-> (outRotate == '0 && outMemReq));

endmodule

bind aln_check_unit aln_check_sva #(.ADDR_W(ADDR_W), .ROT_W(ROT_W)) u_sva (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .outValid(outValid),
  .outFault(outFault), .outMemReq(outMemReq), .outMode(outMode),
  .outAddr(outAddr), .outRotate(outRotate)
);

// File: tb/aln_check_unit_bench.sv
module aln_check_unit_bench;

  localparam int ADDR_W = 32;
  localparam int ROT_W  = 5;

  typedef struct {
    logic              fault;
    logic              memReq;
    logic [1:0]        mode;
    logic [ADDR_W-1:0] addr;
    logic [ROT_W-1:0]  rot;
    string             tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapUnal = 1'b0;
  logic ctrlWe = 1'b0, ctrlStrict = 1'b0, ctrlUnal = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqSize = 2'b00;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic outValid, outFault, outMemReq;
  logic [1:0] outMode;
  logic [ADDR_W-1:0] outAddr;
  logic [ROT_W-1:0] outRotate;

  int total = 0;
  int bad = 0;
  expItem_t sbq[$];
  logic mStrict = 1'b0;
  logic mUnal = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  aln_check_unit u_aln_check_unit (
    .clk(clk), .rstN(rstN), .strapUnal(strapUnal),
    .ctrlWe(ctrlWe), .ctrlStrict(ctrlStrict), .ctrlUnal(ctrlUnal),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqAddr(reqAddr), .outValid(outValid), .outFault(outFault),
    .outMemReq(outMemReq), .outMode(outMode), .outAddr(outAddr),
    .outRotate(outRotate)
  );

  function automatic expItem_t model(logic wr, logic [1:0] sz,
                                     logic [ADDR_W-1:0] a, string tag);
    expItem_t e;
    logic mis;
    mis = (sz == 2'b00) ? 1'b0 : (sz == 2'b01) ? a[0] : (a[1:0] != 2'b00);
    e.tag = tag;
    e.fault = 1'b0; e.memReq = 1'b1; e.mode = 2'd0; e.addr = a; e.rot = '0;
    if (mis && mStrict) begin
      e.fault = 1'b1; e.memReq = 1'b0; e.mode = 2'd3; e.addr = '0;
    end else if (mis && mUnal) begin
      e.mode = 2'd1;
    end else if (mis) begin
      e.mode = 2'd2;
      e.addr = {a[ADDR_W-1:2], 2'b00};
      e.rot = wr ? 5'd0 : 5'(a[1:0]) * 5'd8;
    end
    return e;
  endfunction

  task automatic check(bit ok, string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic drive(logic wr, logic [1:0] sz, logic [ADDR_W-1:0] a,
                       string tag);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = a; ctrlWe = 1'b0;
    sbq.push_back(model(wr, sz, a, tag));
  endtask

  task automatic setCtrl(logic s, logic u);
    @(negedge clk);
    reqValid = 1'b0; ctrlWe = 1'b1; ctrlStrict = s; ctrlUnal = u;
    mStrict = s; mUnal = u;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0; ctrlWe = 1'b0;
    end
  endtask

  task automatic doReset(logic strap);
    @(negedge clk);
    reqValid = 1'b0; ctrlWe = 1'b0; strapUnal = strap; rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mStrict = 1'b0; mUnal = strap;
    check(!outValid && !outFault && !outMemReq,
          $sformatf("R1 reset outputs act=%b%b%b exp=000",
                    outValid, outFault, outMemReq));
  endtask

  // monitor: pops the scoreboard as results appear
  initial begin
    expItem_t e;
    forever begin
      @(negedge clk);
      if (rstN && outValid) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R8 unexpected result act=valid exp=none");
        end else begin
          e = sbq.pop_front();
          check(outFault == e.fault && outMemReq == e.memReq &&
                outMode == e.mode && outAddr == e.addr && outRotate == e.rot,
                $sformatf("%s act f=%b r=%b m=%0d a=%h rot=%0d exp f=%b r=%b m=%0d a=%h rot=%0d",
                          e.tag, outFault, outMemReq, outMode, outAddr, outRotate,
                          e.fault, e.memReq, e.mode, e.addr, e.rot));
        end
      end else if (rstN) begin
        check(!outFault && !outMemReq,
              $sformatf("R8 idle flags act=%b%b exp=00", outFault, outMemReq));
      end
    end
  end

  initial begin
    #1500000;
    check(1'b0, "watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: strap sets unaligned support at reset
    doReset(1'b1);
    drive(1'b0, 2'b10, 32'h0000_1003, "R1 strap=1 pass");
    idle(2);
    doReset(1'b0);
    drive(1'b0, 2'b10, 32'h0000_1002, "R1 strap=0 rotate");
    idle(2);

    // R2 R5 R6 R7: legacy mode, every size and lane, loads and stores
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 4; l++) begin
        drive(1'b0, 2'(s), 32'hA5A5_0100 | 32'(l), "R2 R5 R7 legacy load");
        drive(1'b1, 2'(s), 32'h1234_5670 | 32'(l), "R2 R6 R7 legacy store");
      end
    end
    idle(1);

    // R9: write strict in the same cycle as a misaligned access
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqSize = 2'b10; reqAddr = 32'h0000_2001;
    ctrlWe = 1'b1; ctrlStrict = 1'b1; ctrlUnal = 1'b1;
    sbq.push_back(model(1'b0, 2'b10, 32'h0000_2001, "R9 old bits apply"));
    mStrict = 1'b1; mUnal = 1'b1;
    drive(1'b0, 2'b10, 32'h0000_2001, "R9 R3 new bits apply");

    // R3: strict wins over unaligned support, back to back
    for (int s = 0; s < 3; s++) begin
      for (int l = 0; l < 4; l++) begin
        drive(1'(l), 2'(s), 32'hFFFF_0000 | 32'(l), "R3 R7 strict");
      end
    end
    setCtrl(1'b1, 1'b0);
    drive(1'b0, 2'b01, 32'h0000_0033, "R3 strict without unaligned");
    drive(1'b0, 2'b01, 32'h0000_0032, "R7 aligned half under strict");

    // R4: unaligned pass
    setCtrl(1'b0, 1'b1);
    for (int l = 0; l < 4; l++) begin
      drive(1'(l), 2'b10, 32'h8000_0040 | 32'(l), "R4 pass word");
      drive(1'b0, 2'b01, 32'h8000_0050 | 32'(l), "R4 pass half");
    end
    idle(1);
    drive(1'b0, 2'b11, 32'h7000_0007, "R2 R4 size 3 as word");
    idle(3);
    drive(1'b1, 2'b00, 32'h7000_0003, "R2 R7 byte never misaligned");
    idle(3);

    check(sbq.size() == 0,
          $sformatf("R8 results outstanding act=%0d exp=0", sbq.size()));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule